// File: doc/BRIEF.md
# Floppy controller command/result sequencer

This block is the command engine of a PC-style floppy disk controller as seen from a byte-wide host register port. The host polls a read-only status byte. It writes a command byte by byte into a data port. Once the engine has the full set of bytes for that opcode, it runs a short timed execution phase. It then presents result bytes one at a time on the same data port. Completion is signalled through a level interrupt. The opcodes handled are sense-interrupt, seek, read ID, read and verify. Any other first byte is rejected at once.

When DMA is switched off in the control register, a read command inserts a programmed-I/O data phase before the results. In that phase the host pulls every sector byte through the data port. The bytes come from an internal stub source that produces a counting pattern. There is no media model, drive mechanics or DMA handshake.

The host port has no valid/ready pair. Flow control is the handshake in the status byte. The host may write the data port only while the status shows "ready, host-to-controller". It may read the data port only while the status shows "ready, controller-to-host". A write or read at any other time is dropped without effect. A write is taken on the clock edge where `host_wr` is high. `host_rdata` follows `host_addr` combinationally, and a data-port read advances the engine on the edge where `host_rd` is high.

Top module: `fdc_cmd_seq`

## Requirements
- R1: Status byte at offset 4 has ready at bit 7, direction (1 = to host) at bit 6, programmed-I/O at bit 5 and busy at bit 4, with bits 3:0 zero. When idle it reads 0x80; after the first byte of a multi-byte command it reads 0x90. A data-port write (offset 5) is taken only while ready=1 and direction=0, and is otherwise ignored.
- R2: Command length by opcode: 0x08 takes 1 byte, 0x0F takes 3 bytes, 0x0A takes 2 bytes, and 0xE6 and 0x16 take 9 bytes. The phase changes on the final byte and not before.
- R3: Read ID, read and verify return 7 result bytes, in this order: ST0 = (head<<2)|drive taken from bit 2 and bits 1:0 of command byte 2, then 0x00, then 0x00, then the cylinder, then the head, then the sector, then the size code. For read ID these are the present cylinder, the head bit, 1 and 2. For read and verify they are command bytes 3, 4, 7 (last sector) and 6.
- R4: A sense-interrupt with no seek pending, or any unrecognised first byte, goes straight to a result phase that holds the single byte 0x80.
- R5: A seek has no result phase. When it completes, the interrupt goes high and the present cylinder is updated. A following sense-interrupt returns 0x20|drive and then the cylinder, and drops the interrupt as soon as the command is taken.
- R6: The interrupt from a read ID, read or verify is low during the command and execution phases. It rises on entry to the result phase and falls once the last result byte has been read.
- R7: The execution phase lasts EXEC_CYCLES clocks with status 0x10. The result phase shows status 0xD0.
- R8: With control bit 3 = 0, a read goes through a data phase with status 0xF0. That phase delivers (last - first + 1) × SECT_BYTES bytes, where first and last are command bytes 5 and 7, and byte k reads k mod 256. The results follow. A verify never has a data phase.
- R9: After the final result byte is read, the status reads 0x80.
- R10: The control register at offset 2 is read/write and resets to 0x08. Bit 3 = 1 selects DMA.
- R11: Reading the data port outside the result and data phases returns 0x00 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Register offset: 2 control, 4 status, 5 data |
| host_wr | input | 1 | Write strobe for the addressed register |
| host_rd | input | 1 | Read strobe; pops the data port when it is readable |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Addressed register contents |
| irq | output | 1 | Level interrupt request |

## Verification
A byte counter that is off by one shows up in the status byte on the very next cycle. Busy sticks at 0x90, or the result phase (0xD0) is entered one write too early or too late. A phase that fails to leave the result state is visible as soon as the host reads one byte beyond the expected count, because the status does not return to 0x80. A wrong interrupt flag appears on the port in the same cycle as the phase change, so the bench samples it just before and just after the last result read. Errors in the data-phase length or pattern surface at the first wrong byte, or at the point where the status fails to move from 0xF0 to 0xD0.

// File: rtl/fdcseq_pkg.sv
package fdcseq_pkg;
  localparam int CMD_MAX = 9;
  localparam int RES_MAX = 7;

  localparam logic [2:0] ADDR_CTRL = 3'd2;
  localparam logic [2:0] ADDR_STAT = 3'd4;
  localparam logic [2:0] ADDR_FIFO = 3'd5;
  localparam int         CTRL_DMA  = 3;

  localparam logic [7:0] OP_SENSE  = 8'h08;
  localparam logic [7:0] OP_SEEK   = 8'h0F;
  localparam logic [7:0] OP_RDID   = 8'h0A;
  localparam logic [7:0] OP_READ   = 8'hE6;
  localparam logic [7:0] OP_VERIFY = 8'h16;

  typedef enum logic [1:0] {PH_CMD, PH_EXEC, PH_XFER, PH_RES} phase_t;
  typedef enum logic [2:0] {K_SENSE, K_SEEK, K_RDID, K_READ, K_VERIFY, K_BAD} kind_t;

  function automatic kind_t op_kind(input logic [7:0] op);
    case (op)
      OP_SENSE:  return K_SENSE;
      OP_SEEK:   return K_SEEK;
      OP_RDID:   return K_RDID;
      OP_READ:   return K_READ;
      OP_VERIFY: return K_VERIFY;
      default:   return K_BAD;
    endcase
  endfunction

  function automatic int cmd_len(input kind_t k);
    case (k)
      K_SEEK:            return 3;
      K_RDID:            return 2;
      K_READ, K_VERIFY:  return CMD_MAX;
      default:           return 1;
    endcase
  endfunction
endpackage

// File: rtl/fdcseq_cmdbuf.sv
module fdcseq_cmdbuf #(
  parameter int DEPTH = 9,
  parameter int IDXW  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [IDXW-1:0]       idx,
  input  logic [7:0]            din,
  output logic [DEPTH-1:0][7:0] bytes
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            bytes[i] <= 8'h00;
      else if (push && idx == IDXW'(i))      bytes[i] <= din;
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) push |-> (int'(idx) < DEPTH)); // R2
endmodule

// File: rtl/fdcseq_stub.sv
module fdcseq_stub #(
  parameter int SECT_BYTES = 512,
  parameter int CNT_W      = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] first_sec,
  input  logic [7:0] last_sec,
  input  logic       pop,
  output logic [7:0] data,
  output logic       last
);
  logic [CNT_W-1:0] remain;
  logic [7:0]       pos;
  logic [8:0]       nsec;
  logic [CNT_W-1:0] total;

  always_comb begin
    nsec  = (last_sec >= first_sec) ? ({1'b0, last_sec} - {1'b0, first_sec} + 9'd1) : 9'd1;
    total = CNT_W'(nsec) * CNT_W'(SECT_BYTES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      pos    <= 8'h00;
    end else if (load) begin
      remain <= total;
      pos    <= 8'h00;
    end else if (pop && remain != '0) begin
      remain <= remain - 1'b1;
      pos    <= pos + 8'd1;
    end
  end

  assign data = pos;
  assign last = (remain == CNT_W'(1));

  AST_STUB_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n) pop |-> (remain != '0)); // R8
  AST_STUB_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) load |=> (remain != '0)); // R8
endmodule

// File: rtl/fdcseq_result.sv
module fdcseq_result
  import fdcseq_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  kind_t           kind,
  input  logic [IDXW-1:0] idx,
  input  logic [7:0]      sel_byte,
  input  logic [7:0]      cyl,
  input  logic [7:0]      head,
  input  logic [7:0]      end_sec,
  input  logic [7:0]      size_code,
  input  logic [7:0]      pcn,
  input  logic [7:0]      sense_st0,
  output logic [7:0]      res_byte
);
  logic [7:0] st0;
  assign st0 = {5'b00000, sel_byte[2:0]};

  always_comb begin
    res_byte = 8'h00;
    case (kind)
      K_SENSE: res_byte = (idx == '0) ? sense_st0 : pcn;
      K_BAD:   res_byte = 8'h80;
      K_RDID: begin
        case (int'(idx))
          0: res_byte = st0;
          3: res_byte = pcn;
          4: res_byte = {7'b0, sel_byte[2]};
          5: res_byte = 8'h01;
          6: res_byte = 8'h02;
          default: res_byte = 8'h00;
        endcase
      end
      default: begin
        case (int'(idx))
          0: res_byte = st0;
          3: res_byte = cyl;
          4: res_byte = head;
          5: res_byte = end_sec;
          6: res_byte = size_code;
          default: res_byte = 8'h00;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdcseq_pkg::*;
#(
  parameter int EXEC_CYCLES = 8,
  parameter int SECT_BYTES  = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq
);
  localparam int EXW   = (EXEC_CYCLES > 1) ? $clog2(EXEC_CYCLES) : 1;
  localparam int IDXW  = $clog2(CMD_MAX + 1);
  localparam int CNT_W = $clog2(256 * SECT_BYTES + 1);

  phase_t                 phase;
  kind_t                  kind, new_kind;
  logic [IDXW-1:0]        cnt, res_len;
  logic [EXW-1:0]         exec_cnt;
  logic [7:0]             ctrl, pcn, sense_st0, status, res_byte, stub_data;
  logic                   seek_pend, res_irq, stub_last, stub_load, stub_pop;
  logic [1:0]             seek_drv;
  logic [CMD_MAX-1:0][7:0] cmdb;
  logic                   wr_fifo, rd_fifo, cmd_ok, cmd_done, res_pop;
  logic                   unused_cmd;

  assign wr_fifo   = host_wr && host_addr == ADDR_FIFO;
  assign rd_fifo   = host_rd && host_addr == ADDR_FIFO;
  assign cmd_ok    = wr_fifo && phase == PH_CMD;
  assign new_kind  = (cnt == '0) ? op_kind(host_wdata) : kind;
  assign cmd_done  = cmd_ok && (int'(cnt) + 1 == cmd_len(new_kind));
  assign res_pop   = rd_fifo && phase == PH_RES;
  assign stub_pop  = rd_fifo && phase == PH_XFER;
  assign stub_load = phase == PH_EXEC && exec_cnt == '0 && kind == K_READ && !ctrl[CTRL_DMA];
  assign unused_cmd = ^{cmdb[0], cmdb[7], cmdb[8]};

  fdcseq_cmdbuf #(.DEPTH(CMD_MAX), .IDXW(IDXW)) i_cmdbuf (
    .clk(clk), .rst_n(rst_n), .push(cmd_ok), .idx(cnt), .din(host_wdata), .bytes(cmdb)
  );

  fdcseq_stub #(.SECT_BYTES(SECT_BYTES), .CNT_W(CNT_W)) i_stub (
    .clk(clk), .rst_n(rst_n), .load(stub_load), .first_sec(cmdb[4]), .last_sec(cmdb[6]),
    .pop(stub_pop), .data(stub_data), .last(stub_last)
  );

  fdcseq_result #(.IDXW(IDXW)) i_result (
    .kind(kind), .idx(cnt), .sel_byte(cmdb[1]), .cyl(cmdb[2]), .head(cmdb[3]),
    .end_sec(cmdb[6]), .size_code(cmdb[5]), .pcn(pcn), .sense_st0(sense_st0),
    .res_byte(res_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      kind      <= K_BAD;
      cnt       <= '0;
      res_len   <= '0;
      exec_cnt  <= '0;
      pcn       <= 8'h00;
      sense_st0 <= 8'h80;
      seek_pend <= 1'b0;
      seek_drv  <= 2'b00;
      res_irq   <= 1'b0;
    end else begin
      case (phase)
        PH_CMD: if (cmd_ok) begin
          if (cnt == '0) kind <= new_kind;
          if (cmd_done) begin
            cnt <= '0;
            case (new_kind)
              K_SENSE: begin
                phase     <= PH_RES;
                res_len   <= seek_pend ? IDXW'(2) : IDXW'(1);
                sense_st0 <= seek_pend ? {6'b001000, seek_drv} : 8'h80;
                seek_pend <= 1'b0;
              end
              K_BAD: begin
                phase   <= PH_RES;
                res_len <= IDXW'(1);
              end
              default: begin
                phase    <= PH_EXEC;
                exec_cnt <= EXW'(EXEC_CYCLES - 1);
              end
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_EXEC: begin
          if (exec_cnt != '0) begin
            exec_cnt <= exec_cnt - 1'b1;
          end else if (kind == K_SEEK) begin
            pcn       <= cmdb[2];
            seek_pend <= 1'b1;
            seek_drv  <= cmdb[1][1:0];
            phase     <= PH_CMD;
          end else if (kind == K_READ && !ctrl[CTRL_DMA]) begin
            phase <= PH_XFER;
          end else begin
            phase   <= PH_RES;
            res_len <= IDXW'(RES_MAX);
            res_irq <= 1'b1;
          end
        end
        PH_XFER: if (stub_pop && stub_last) begin
          phase   <= PH_RES;
          res_len <= IDXW'(RES_MAX);
          res_irq <= 1'b1;
        end
        default: if (res_pop) begin
          if (cnt == res_len - 1'b1) begin
            phase   <= PH_CMD;
            cnt     <= '0;
            res_irq <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  ctrl <= 8'h08;
    else if (host_wr && host_addr == ADDR_CTRL)  ctrl <= host_wdata;
  end

  always_comb begin
    case (phase)
      PH_CMD:  status = {1'b1, 1'b0, 1'b0, cnt != '0, 4'h0};
      PH_EXEC: status = 8'h10;
      PH_XFER: status = 8'hF0;
      default: status = 8'hD0;
    endcase
  end

  always_comb begin
    case (host_addr)
      ADDR_CTRL: host_rdata = ctrl;
      ADDR_STAT: host_rdata = status;
      ADDR_FIFO: host_rdata = (phase == PH_RES) ? res_byte :
                              (phase == PH_XFER) ? stub_data : 8'h00;
      default:   host_rdata = 8'h00;
    endcase
  end

  assign irq = res_irq | seek_pend;

  AST_RES_IGNORES_WR: assert property (@(posedge clk) disable iff (!rst_n) (wr_fifo && !host_rd && phase == PH_RES) |=> (phase == PH_RES && $stable(cnt))); // R1
  AST_IRQ_QUIET_CMD: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_CMD) |-> !res_irq); // R6
  AST_IRQ_ON_RESULTS: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_RES && $past(phase) != PH_RES && kind inside {K_RDID, K_READ, K_VERIFY}) |-> irq); // R6
  AST_LAST_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (res_pop && cnt == res_len - 1'b1) |=> (host_addr != ADDR_STAT || host_rdata == 8'h80)); // R9
  AST_SEEK_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_EXEC && kind == K_SEEK && exec_cnt == '0) |=> (phase == PH_CMD && irq)); // R5
  AST_SENSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (cmd_done && new_kind == K_SENSE) |=> !seek_pend); // R5
  AST_XFER_NOT_DMA: assert property (@(posedge clk) disable iff (!rst_n) stub_load |=> (phase == PH_XFER)); // R8
endmodule

// File: tb/test_fdc_cmd_seq.sv
module test_fdc_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int EXEC = 4;
  localparam int SECT = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = 3'd4;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       irq;

  int tests = 0;
  int failed = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fdc_cmd_seq #(.EXEC_CYCLES(EXEC), .SECT_BYTES(SECT)) i_fdc_cmd_seq (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic chk_stat(input string tag, input logic [7:0] exp);
    logic [7:0] s;
    peek(3'd4, s);
    chk(tag, s, exp);
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    #1;
    chk(tag, {7'b0, irq}, {7'b0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send9(input logic [7:0] op, input logic [7:0] sel, input logic [7:0] c,
                       input logic [7:0] h, input logic [7:0] r, input logic [7:0] n,
                       input logic [7:0] eot);
    wr(3'd5, op);
    chk_stat("R2 busy after first of 9", 8'h90);
    wr(3'd5, sel); wr(3'd5, c); wr(3'd5, h); wr(3'd5, r);
    wr(3'd5, n); wr(3'd5, eot); wr(3'd5, 8'h1B);
    chk_stat("R2 still collecting at byte 8", 8'h90);
    wr(3'd5, 8'hFF);
    chk_stat("R7 exec status after 9th byte", 8'h10);
    chk_irq("R6 irq low in exec", 1'b0);
  endtask

  task automatic take_results(input string tag, input logic [7:0] e0, input logic [7:0] e3,
                              input logic [7:0] e4, input logic [7:0] e5, input logic [7:0] e6);
    logic [7:0] v;
    logic [7:0] exp [7];
    exp = '{e0, 8'h00, 8'h00, e3, e4, e5, e6};
    chk_stat({tag, " R7 result status"}, 8'hD0);
    chk_irq({tag, " R6 irq up at results"}, 1'b1);
    for (int i = 0; i < 7; i++) begin
      if (i == 6) chk_irq({tag, " R6 irq held before last"}, 1'b1);
      rd(3'd5, v);
      chk($sformatf("%s R3 result byte %0d", tag, i), v, exp[i]);
    end
    chk_irq({tag, " R6 irq down after last"}, 1'b0);
    chk_stat({tag, " R9 back to idle"}, 8'h80);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk_stat("R1 reset status", 8'h80);
    peek(3'd2, v);
    chk("R10 reset ctrl", v, 8'h08);
    chk_irq("R6 reset irq", 1'b0);
    rd(3'd5, v);
    chk("R11 idle data read", v, 8'h00);
    chk_stat("R11 status unchanged", 8'h80);
  endtask

  task automatic t_sense_idle;
    logic [7:0] v;
    wr(3'd5, 8'h08);
    chk_stat("R4 sense enters results at once", 8'hD0);
    chk_irq("R4 sense raises no irq", 1'b0);
    rd(3'd5, v);
    chk("R4 sense idle byte", v, 8'h80);
    chk_stat("R9 single byte ends", 8'h80);
  endtask

  task automatic t_bad_op;
    logic [7:0] v;
    wr(3'd5, 8'h55);
    chk_stat("R4 bad opcode result", 8'hD0);
    rd(3'd5, v);
    chk("R4 bad opcode byte", v, 8'h80);
    chk_stat("R9 bad opcode done", 8'h80);
  endtask

  task automatic t_seek(input logic [7:0] sel, input logic [7:0] cyl);
    logic [7:0] v;
    wr(3'd5, 8'h0F);
    chk_stat("R1 busy after first byte", 8'h90);
    wr(3'd5, sel);
    chk_stat("R2 seek still collecting", 8'h90);
    wr(3'd5, cyl);
    chk_stat("R7 seek exec", 8'h10);
    wr(3'd5, 8'hAA);
    chk_irq("R6 irq low in seek exec", 1'b0);
    idle(EXEC);
    chk_stat("R1 ignored write left no byte", 8'h80);
    chk_irq("R5 seek end irq", 1'b1);
    wr(3'd5, 8'h08);
    chk_irq("R5 sense drops irq", 1'b0);
    rd(3'd5, v);
    chk("R5 sense st0", v, 8'h20 | {6'b0, sel[1:0]});
    rd(3'd5, v);
    chk("R5 sense cylinder", v, cyl);
    chk_stat("R9 sense done", 8'h80);
  endtask

  task automatic t_read_id;
    logic [7:0] v;
    wr(3'd5, 8'h0A);
    chk_stat("R2 read id collecting", 8'h90);
    wr(3'd5, 8'h06);
    chk_stat("R7 read id exec", 8'h10);
    chk_irq("R6 read id exec irq", 1'b0);
    idle(EXEC - 1);
    chk_stat("R7 exec lasts EXEC cycles", 8'h10);
    idle(1);
    take_results("rdid", 8'h06, 8'h08, 8'h01, 8'h01, 8'h02);
    rd(3'd5, v);
    chk("R11 extra read is zero", v, 8'h00);
  endtask

  task automatic t_read_ndma(input logic [7:0] first, input logic [7:0] last_s);
    logic [7:0] v;
    int nbytes;
    nbytes = (int'(last_s) - int'(first) + 1) * SECT;
    wr(3'd2, 8'h00);
    peek(3'd2, v);
    chk("R10 ctrl written", v, 8'h00);
    send9(8'hE6, 8'h00, 8'h03, 8'h00, first, 8'h02, last_s);
    idle(EXEC);
    chk_stat("R8 data phase status", 8'hF0);
    chk_irq("R8 no irq in data phase", 1'b0);
    for (int k = 0; k < nbytes; k++) begin
      if (k == nbytes - 1) chk_stat("R8 still in data phase", 8'hF0);
      rd(3'd5, v);
      if (v !== 8'(k) || k == 0 || k == nbytes - 1)
        chk($sformatf("R8 data byte %0d", k), v, 8'(k));
    end
    take_results("ndma", 8'h00, 8'h03, 8'h00, last_s, 8'h02);
  endtask

  initial begin
    logic [7:0] v;
    fork
      begin
        repeat (200000) @(posedge clk);
        failed++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
      end
    join_none
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_sense_idle();
    t_bad_op();
    t_seek(8'h01, 8'h05);
    t_seek(8'h06, 8'h08);
    t_read_id();
    send9(8'hE6, 8'h00, 8'h03, 8'h00, 8'h01, 8'h02, 8'h02);
    idle(EXEC);
    take_results("read dma", 8'h00, 8'h03, 8'h00, 8'h02, 8'h02);
    send9(8'h16, 8'h07, 8'h0C, 8'h01, 8'h04, 8'h02, 8'h09);
    idle(EXEC);
    take_results("verify", 8'h07, 8'h0C, 8'h01, 8'h09, 8'h02);
    t_read_ndma(8'h01, 8'h02);
    t_read_ndma(8'h05, 8'h05);
    send9(8'h16, 8'h04, 8'h01, 8'h01, 8'h01, 8'h02, 8'h03);
    idle(EXEC);
    take_results("R8 verify no data phase", 8'h04, 8'h01, 8'h01, 8'h03, 8'h02);
    wr(3'd2, 8'h08);
    peek(3'd2, v);
    chk("R10 ctrl restore", v, 8'h08);
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule